// File: doc/BRIEF.md
# Security Module Command Exchange Sequencer

This block carries out one complete command/response exchange with a trusted-platform security device that exposes a status register and a byte FIFO. On a start pulse it checks the size field inside a command held in an external buffer and announces the command to the device. It then streams the command bytes into the device FIFO, tells the device to execute, and polls the status register once per millisecond until a response is ready or a timeout expires.

The response is read into an external buffer byte by byte. The block first takes a six-byte header that carries the total length. It reads every byte except the last one, confirms that the device still reports pending data, then reads the final byte and confirms that pending data has gone. A successful exchange ends by placing the device back in its ready state and reporting the response length. Any failure returns the block to idle and raises an error strobe with a code that identifies the failure. The host builds commands and interprets responses; the block does neither.

Top module: `tpm_xchg_ctrl`

## Requirements
- R1: After reset, busy, done, err_stb, rsp_we, reg_req and fifo_req are all low.
- R2: The command size field is bytes 2..5 of the command buffer, most significant byte first. When it differs from cmd_len, or when cmd_len is below 6, the exchange ends with err_code 1 and no register or FIFO access takes place.
- R3: The block first writes 0x40 (command ready, bit 6) to the status register. It then writes command bytes 0 to cmd_len-1 to the FIFO in ascending order.
- R4: Once the last command byte has been accepted, the block writes 0x20 (go, bit 5) to the status register.
- R5: After go, the block issues one status read per millisecond tick. It moves on to the response as soon as a read shows bit 7 (valid) and bit 4 (data available) both set.
- R6: When TIMEOUT_MS polls have failed, the exchange ends with err_code 2.
- R7: The block reads six header bytes from the FIFO and stores them at buffer addresses 0..5. Every response byte is stored at its own offset. The response length is taken from header bytes 2..5, most significant byte first.
- R8: If the response length is greater than max_rsp or less than 7, the exchange ends with err_code 3 and no further access takes place.
- R9: After reading bytes up to length-2, the block reads status. Unless bits 7 and 4 are both set, the exchange ends with err_code 4 and the last byte is not read.
- R10: After reading the last byte, the block reads status. Unless bit 7 is set and bit 4 is clear, the exchange ends with err_code 5.
- R11: On success the block writes 0x40 to the status register, then pulses done with err_code 0 and rsp_len equal to the response length.
- R12: busy is high from start until completion. done and err_stb are single-cycle pulses that are never high together, and err_stb always carries a nonzero code.
- R13: reg_req and fifo_req are never high together, and each stays high until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange (accepted while idle) |
| cmd_len | input | LEN_W | Command length in bytes |
| max_rsp | input | LEN_W | Largest allowed response length |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Success pulse |
| err_stb | output | 1 | Failure pulse |
| err_code | output | 3 | Failure cause (0 none, 1 command size, 2 timeout, 3 response size, 4 mid status, 5 end status) |
| rsp_len | output | LEN_W | Response length of the last successful exchange |
| cmd_rd_addr | output | LEN_W | Command buffer read address |
| cmd_rd_data | input | 8 | Command buffer data, one cycle after the address |
| rsp_we | output | 1 | Response buffer write strobe |
| rsp_addr | output | LEN_W | Response buffer write address |
| rsp_data | output | 8 | Response buffer write data |
| reg_req | output | 1 | Status register access request |
| reg_wr | output | 1 | 1 = write, 0 = read |
| reg_wdata | output | 32 | Status value to write |
| reg_ack | input | 1 | Register access done (one-cycle pulse) |
| reg_rdata | input | 32 | Status value read, valid with reg_ack |
| fifo_req | output | 1 | FIFO byte transfer request |
| fifo_wr | output | 1 | 1 = write, 0 = read |
| fifo_wdata | output | 8 | FIFO byte to write |
| fifo_ack | input | 1 | FIFO transfer done (one-cycle pulse) |
| fifo_rdata | input | 8 | FIFO byte read, valid with fifo_ack |

## Verification
A sequencer stuck in the wrong state or holding a wrong byte index shows up at the ports within one bus transfer. It appears as an unexpected status write, a command byte out of order, or a response byte stored at the wrong address, and the scoreboard catches the first such event. Faults in the length or status checks show up as a wrong err_code, or as a missing final ready write, on the strobe that ends the exchange. A faulty timer shows up as a wrong number of polls before the timeout code.

// File: rtl/tpm_xchg_pkg.sv
package tpm_xchg_pkg;
  localparam int STS_W = 32;
  localparam logic [STS_W-1:0] STS_WR_READY = 32'h0000_0040;
  localparam logic [STS_W-1:0] STS_WR_GO    = 32'h0000_0020;
  localparam logic [STS_W-1:0] STS_VALID    = 32'h0000_0080;
  localparam logic [STS_W-1:0] STS_AVAIL    = 32'h0000_0010;
  localparam int HDR_BYTES = 6;
  localparam int SIZE_FIRST = 2;
  localparam int SIZE_LAST  = 5;
  localparam int MIN_RSP    = HDR_BYTES + 1;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_CMD_SIZE = 3'd1,
    ERR_TIMEOUT  = 3'd2,
    ERR_RSP_SIZE = 3'd3,
    ERR_MID_STS  = 3'd4,
    ERR_END_STS  = 3'd5
  } xerr_e;

  typedef enum logic [4:0] {
    S_IDLE, S_CK_WAIT, S_CK_USE, S_CK_CMP, S_WR_RDY,
    S_TX_WAIT, S_TX_LOAD, S_TX_SEND, S_WR_GO,
    S_POLL_WAIT, S_POLL_RD, S_HDR_RD, S_RSZ_CHK,
    S_BODY_RD, S_MID_STS, S_LAST_RD, S_END_STS, S_WR_IDLE
  } xstate_e;
endpackage

// File: rtl/xchg_ms_timer.sv
module xchg_ms_timer #(
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 120000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic expired
);
  localparam int PRE_W = $clog2(CYC_PER_MS + 1);
  localparam int MS_W  = $clog2(TIMEOUT_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_LIMIT = MS_W'(TIMEOUT_MS);

  logic [PRE_W-1:0] pre_cnt;
  logic [MS_W-1:0]  ms_cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_cnt == PRE_LAST) begin
        pre_cnt <= '0;
        tick    <= 1'b1;
        if (ms_cnt != MS_LIMIT) ms_cnt <= ms_cnt + MS_W'(1);
      end else begin
        pre_cnt <= pre_cnt + PRE_W'(1);
      end
    end
  end

  assign expired = (ms_cnt >= MS_LIMIT);

  // once the limit is reached it stays reached while the timer runs
  assert_expired_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (run && expired) |=> expired);

  generate
    if (CYC_PER_MS > 1) begin : g_tick_gap
      assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/xchg_be_word.sv
module xchg_be_word #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else if (shift) word <= {word[WORD_W-BYTE_W-1:0], byte_in};
  end

  // newest byte always lands in the least significant position
  assert_shift_lsb_R7: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr) |=> (word[BYTE_W-1:0] == $past(byte_in)));
endmodule

// File: rtl/xchg_sts_eval.sv
module xchg_sts_eval
  import tpm_xchg_pkg::*;
(
  input  logic [STS_W-1:0] sts,
  output logic             has_data,
  output logic             drained
);
  localparam logic [STS_W-1:0] CHK_MASK = STS_VALID | STS_AVAIL;

  always_comb begin
    has_data = ((sts & CHK_MASK) == CHK_MASK);
    drained  = ((sts & CHK_MASK) == STS_VALID);
  end
endmodule

// File: rtl/tpm_xchg_ctrl.sv
module tpm_xchg_ctrl
  import tpm_xchg_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int CYC_PER_MS = 100000,
  parameter int TIMEOUT_MS = 120000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [LEN_W-1:0] max_rsp,
  output logic             busy,
  output logic             done,
  output logic             err_stb,
  output logic [2:0]       err_code,
  output logic [LEN_W-1:0] rsp_len,
  output logic [LEN_W-1:0] cmd_rd_addr,
  input  logic [7:0]       cmd_rd_data,
  output logic             rsp_we,
  output logic [LEN_W-1:0] rsp_addr,
  output logic [7:0]       rsp_data,
  output logic             reg_req,
  output logic             reg_wr,
  output logic [31:0]      reg_wdata,
  input  logic             reg_ack,
  input  logic [31:0]      reg_rdata,
  output logic             fifo_req,
  output logic             fifo_wr,
  output logic [7:0]       fifo_wdata,
  input  logic             fifo_ack,
  input  logic [7:0]       fifo_rdata
);
  localparam int WORD_W = 32;
  localparam logic [LEN_W-1:0] ONE       = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO       = LEN_W'(2);
  localparam logic [LEN_W-1:0] HDR_LEN   = LEN_W'(HDR_BYTES);
  localparam logic [LEN_W-1:0] IDX_FIRST = LEN_W'(SIZE_FIRST);
  localparam logic [LEN_W-1:0] IDX_LAST  = LEN_W'(SIZE_LAST);
  localparam logic [LEN_W-1:0] HDR_END   = LEN_W'(HDR_BYTES - 1);
  localparam logic [WORD_W-1:0] MIN_WORD = WORD_W'(MIN_RSP);

  xstate_e          st;
  logic [LEN_W-1:0] idx, len_q, max_q, rsz_q;
  logic             acc_clr, acc_shift;
  logic [7:0]       acc_byte;
  logic [WORD_W-1:0] size_word;
  logic             tmr_run, tmr_tick, tmr_expired;
  logic             sts_has_data, sts_drained;

  // size field accumulator: command bytes during the check, FIFO bytes in the header
  assign acc_clr   = (st == S_IDLE) || (st == S_WR_GO);
  assign acc_shift = (st == S_CK_USE) ||
                     ((st == S_HDR_RD) && fifo_ack && (idx >= IDX_FIRST));
  assign acc_byte  = (st == S_CK_USE) ? cmd_rd_data : fifo_rdata;

  xchg_be_word #(.BYTE_W(8), .WORD_W(WORD_W)) u_size_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .shift(acc_shift),
    .byte_in(acc_byte), .word(size_word)
  );

  assign tmr_run = (st == S_POLL_WAIT) || (st == S_POLL_RD);

  xchg_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .tick(tmr_tick), .expired(tmr_expired)
  );

  xchg_sts_eval u_sts (
    .sts(reg_rdata), .has_data(sts_has_data), .drained(sts_drained)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      idx         <= '0;
      len_q       <= '0;
      max_q       <= '0;
      rsz_q       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      err_stb     <= 1'b0;
      err_code    <= ERR_NONE;
      rsp_len     <= '0;
      cmd_rd_addr <= '0;
      rsp_we      <= 1'b0;
      rsp_addr    <= '0;
      rsp_data    <= '0;
      reg_req     <= 1'b0;
      reg_wr      <= 1'b0;
      reg_wdata   <= '0;
      fifo_req    <= 1'b0;
      fifo_wr     <= 1'b0;
      fifo_wdata  <= '0;
    end else begin
      done    <= 1'b0;
      err_stb <= 1'b0;
      rsp_we  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            len_q <= cmd_len;
            max_q <= max_rsp;
            if (cmd_len < HDR_LEN) begin
              err_stb  <= 1'b1;
              err_code <= ERR_CMD_SIZE;
            end else begin
              busy        <= 1'b1;
              idx         <= IDX_FIRST;
              cmd_rd_addr <= IDX_FIRST;
              st          <= S_CK_WAIT;
            end
          end
        end
        S_CK_WAIT: st <= S_CK_USE;
        S_CK_USE: begin
          if (idx == IDX_LAST) begin
            st <= S_CK_CMP;
          end else begin
            idx         <= idx + ONE;
            cmd_rd_addr <= idx + ONE;
            st          <= S_CK_WAIT;
          end
        end
        S_CK_CMP: begin
          if (size_word == WORD_W'(len_q)) begin
            reg_req   <= 1'b1;
            reg_wr    <= 1'b1;
            reg_wdata <= STS_WR_READY;
            st        <= S_WR_RDY;
          end else begin
            err_stb  <= 1'b1;
            err_code <= ERR_CMD_SIZE;
            busy     <= 1'b0;
            st       <= S_IDLE;
          end
        end
        S_WR_RDY: begin
          if (reg_ack) begin
            reg_req     <= 1'b0;
            idx         <= '0;
            cmd_rd_addr <= '0;
            st          <= S_TX_WAIT;
          end
        end
        S_TX_WAIT: st <= S_TX_LOAD;
        S_TX_LOAD: begin
          fifo_req   <= 1'b1;
          fifo_wr    <= 1'b1;
          fifo_wdata <= cmd_rd_data;
          st         <= S_TX_SEND;
        end
        S_TX_SEND: begin
          if (fifo_ack) begin
            fifo_req <= 1'b0;
            if (idx == len_q - ONE) begin
              reg_req   <= 1'b1;
              reg_wr    <= 1'b1;
              reg_wdata <= STS_WR_GO;
              st        <= S_WR_GO;
            end else begin
              idx         <= idx + ONE;
              cmd_rd_addr <= idx + ONE;
              st          <= S_TX_WAIT;
            end
          end
        end
        S_WR_GO: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            st      <= S_POLL_WAIT;
          end
        end
        S_POLL_WAIT: begin
          if (tmr_tick) begin
            reg_req <= 1'b1;
            reg_wr  <= 1'b0;
            st      <= S_POLL_RD;
          end
        end
        S_POLL_RD: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            if (sts_has_data) begin
              idx      <= '0;
              fifo_req <= 1'b1;
              fifo_wr  <= 1'b0;
              st       <= S_HDR_RD;
            end else if (tmr_expired) begin
              err_stb  <= 1'b1;
              err_code <= ERR_TIMEOUT;
              busy     <= 1'b0;
              st       <= S_IDLE;
            end else begin
              st <= S_POLL_WAIT;
            end
          end
        end
        S_HDR_RD: begin
          if (fifo_ack) begin
            rsp_we   <= 1'b1;
            rsp_addr <= idx;
            rsp_data <= fifo_rdata;
            if (idx == HDR_END) begin
              fifo_req <= 1'b0;
              st       <= S_RSZ_CHK;
            end else begin
              idx <= idx + ONE;
            end
          end
        end
        S_RSZ_CHK: begin
          if ((size_word > WORD_W'(max_q)) || (size_word < MIN_WORD)) begin
            err_stb  <= 1'b1;
            err_code <= ERR_RSP_SIZE;
            busy     <= 1'b0;
            st       <= S_IDLE;
          end else begin
            rsz_q <= size_word[LEN_W-1:0];
            idx   <= HDR_LEN;
            if (size_word == MIN_WORD) begin
              reg_req <= 1'b1;
              reg_wr  <= 1'b0;
              st      <= S_MID_STS;
            end else begin
              fifo_req <= 1'b1;
              fifo_wr  <= 1'b0;
              st       <= S_BODY_RD;
            end
          end
        end
        S_BODY_RD: begin
          if (fifo_ack) begin
            rsp_we   <= 1'b1;
            rsp_addr <= idx;
            rsp_data <= fifo_rdata;
            if (idx == rsz_q - TWO) begin
              fifo_req <= 1'b0;
              reg_req  <= 1'b1;
              reg_wr   <= 1'b0;
              st       <= S_MID_STS;
            end else begin
              idx <= idx + ONE;
            end
          end
        end
        S_MID_STS: begin
          if (reg_ack) begin
            reg_req <= 1'b0;
            if (sts_has_data) begin
              idx      <= rsz_q - ONE;
              fifo_req <= 1'b1;
              fifo_wr  <= 1'b0;
              st       <= S_LAST_RD;
            end else begin
              err_stb  <= 1'b1;
              err_code <= ERR_MID_STS;
              busy     <= 1'b0;
              st       <= S_IDLE;
            end
          end
        end
        S_LAST_RD: begin
          if (fifo_ack) begin
            fifo_req <= 1'b0;
            rsp_we   <= 1'b1;
            rsp_addr <= idx;
            rsp_data <= fifo_rdata;
            reg_req  <= 1'b1;
            reg_wr   <= 1'b0;
            st       <= S_END_STS;
          end
        end
        S_END_STS: begin
          if (reg_ack) begin
            if (sts_drained) begin
              reg_wr    <= 1'b1;
              reg_wdata <= STS_WR_READY;
              st        <= S_WR_IDLE;
            end else begin
              reg_req  <= 1'b0;
              err_stb  <= 1'b1;
              err_code <= ERR_END_STS;
              busy     <= 1'b0;
              st       <= S_IDLE;
            end
          end
        end
        S_WR_IDLE: begin
          if (reg_ack) begin
            reg_req  <= 1'b0;
            done     <= 1'b1;
            err_code <= ERR_NONE;
            rsp_len  <= rsz_q;
            busy     <= 1'b0;
            st       <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // the two device ports are never requested together
  assert_port_excl_R13: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && fifo_req));
  // a pending register request is held until acknowledged
  assert_reg_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) |=> reg_req);
  // a pending FIFO request is held until acknowledged
  assert_fifo_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (fifo_req && !fifo_ack) |=> fifo_req);
  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(done && err_stb));
  assert_err_code_R12: assert property (@(posedge clk) disable iff (rst)
    err_stb |-> (err_code != ERR_NONE));
  // a reported length always lies within the accepted range
  assert_done_len_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ((rsp_len >= LEN_W'(MIN_RSP)) && (rsp_len <= max_q)));
  // go is requested only once the final command byte has been handed over
  assert_go_after_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(reg_req) && reg_wr && (reg_wdata == STS_WR_GO)) |-> (idx == len_q - ONE));
  // the response buffer is written only while response bytes arrive
  assert_rsp_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_we |-> $past(fifo_ack && !fifo_wr));
endmodule

// File: tb/tpm_xchg_ctrl_bench.sv
module tpm_xchg_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam int CYC_PER_MS = 8;
  localparam int TIMEOUT_MS = 10;
  localparam int K_STS = 1, K_CMD = 2, K_RSP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [LEN_W-1:0] cmd_len = '0, max_rsp = '0;
  logic busy, done, err_stb;
  logic [2:0] err_code;
  logic [LEN_W-1:0] rsp_len, cmd_rd_addr, rsp_addr;
  logic [7:0] cmd_rd_data = '0;
  logic rsp_we;
  logic [7:0] rsp_data;
  logic reg_req, reg_wr, fifo_req, fifo_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic reg_ack = 1'b0, fifo_ack = 1'b0;
  logic [7:0] fifo_wdata;
  logic [7:0] fifo_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpm_xchg_ctrl #(.LEN_W(LEN_W), .CYC_PER_MS(CYC_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_tpm_xchg_ctrl (
    .clk(clk), .rst(rst), .start(start), .cmd_len(cmd_len), .max_rsp(max_rsp),
    .busy(busy), .done(done), .err_stb(err_stb), .err_code(err_code), .rsp_len(rsp_len),
    .cmd_rd_addr(cmd_rd_addr), .cmd_rd_data(cmd_rd_data),
    .rsp_we(rsp_we), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .fifo_req(fifo_req), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_ack(fifo_ack), .fifo_rdata(fifo_rdata)
  );

  // device model configuration, written by the driver only
  logic [7:0] cmd_mem [0:255];
  logic [7:0] dev_mem [0:255];
  int rsp_total = 0, ready_after = 0, fault = 0;
  logic dev_clr = 1'b0;
  logic [31:0] exp_q [$];

  // device model state, written by the model only
  int rd_idx = 0, wr_idx = 0, polls = 0, sts_writes = 0;
  logic go_seen = 1'b0, rdy = 1'b0;
  int mon_checks = 0, mon_fails = 0;

  int tb_checks = 0, tb_fails = 0, wd_fail = 0;

  function automatic logic [31:0] mk_ev(input int k, input int a, input int v);
    return {k[3:0], a[11:0], v[15:0]};
  endfunction

  task automatic observe(input logic [31:0] ev);
    logic [31:0] e;
    mon_checks++;
    if (exp_q.size() == 0) begin
      mon_fails++;
      $display("FAIL R3 unexpected event act=%h exp=none", ev);
    end else begin
      e = exp_q.pop_front();
      if (e !== ev) begin
        mon_fails++;
        if (ev[31:28] == 4'(K_STS))      $display("FAIL R4 status write act=%h exp=%h", ev, e);
        else if (ev[31:28] == 4'(K_CMD)) $display("FAIL R3 command byte act=%h exp=%h", ev, e);
        else                             $display("FAIL R7 response byte act=%h exp=%h", ev, e);
      end
    end
    mon_checks++;
    if (reg_req && fifo_req) begin
      mon_fails++;
      $display("FAIL R13 both ports requested act=1 exp=0");
    end
  endtask

  always @(posedge clk) cmd_rd_data <= cmd_mem[cmd_rd_addr];

  always @(posedge clk) begin
    reg_ack  <= 1'b0;
    fifo_ack <= 1'b0;
    if (dev_clr) begin
      rd_idx <= 0; wr_idx <= 0; polls <= 0; sts_writes <= 0;
      go_seen <= 1'b0; rdy <= 1'b0;
    end else begin
      if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        if (reg_wr) begin
          sts_writes <= sts_writes + 1;
          if (reg_wdata == 32'h20) go_seen <= 1'b1;
          observe(mk_ev(K_STS, 0, int'(reg_wdata[15:0])));
        end else begin
          automatic logic r = rdy || (go_seen && ready_after != 0 && polls + 1 >= ready_after);
          automatic logic av;
          if (go_seen && !rdy) polls <= polls + 1;
          if (r) rdy <= 1'b1;
          av = r && (rd_idx < rsp_total);
          if (fault == 1 && rd_idx == rsp_total - 1) av = 1'b0;
          if (fault == 2 && rd_idx == rsp_total) av = 1'b1;
          reg_rdata <= {24'h0, 1'b1, 2'b00, av, 4'b0000};
        end
      end
      if (fifo_req && !fifo_ack) begin
        fifo_ack <= 1'b1;
        if (fifo_wr) begin
          observe(mk_ev(K_CMD, wr_idx, int'(fifo_wdata)));
          wr_idx <= wr_idx + 1;
        end else begin
          fifo_rdata <= dev_mem[rd_idx];
          rd_idx <= rd_idx + 1;
        end
      end
    end
    if (rsp_we) observe(mk_ev(K_RSP, int'(rsp_addr), int'(rsp_data)));
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic string code_req(input int c);
    case (c)
      0: return "R11";
      1: return "R2";
      2: return "R6";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  // driver: load buffers, push the expected event stream, run one exchange
  task automatic run_xchg(input int clen, input int field, input int rsz, input int rdy_after,
                          input int flt, input int maxr, input int exp_code);
    int n;
    for (int i = 0; i < 256; i++) begin
      cmd_mem[i] = 8'(i * 5 + 1);
      dev_mem[i] = 8'(i * 7 + 3);
    end
    cmd_mem[0] = 8'h80; cmd_mem[1] = 8'h01;
    cmd_mem[2] = 8'(field >> 24); cmd_mem[3] = 8'(field >> 16);
    cmd_mem[4] = 8'(field >> 8);  cmd_mem[5] = 8'(field);
    dev_mem[0] = 8'h80; dev_mem[1] = 8'h04;
    dev_mem[2] = 8'(rsz >> 24); dev_mem[3] = 8'(rsz >> 16);
    dev_mem[4] = 8'(rsz >> 8);  dev_mem[5] = 8'(rsz);
    rsp_total = rsz; ready_after = rdy_after; fault = flt;
    @(negedge clk) dev_clr = 1'b1;
    @(negedge clk) dev_clr = 1'b0;
    if (exp_code != 1) begin
      exp_q.push_back(mk_ev(K_STS, 0, 'h40));
      for (int i = 0; i < clen; i++) exp_q.push_back(mk_ev(K_CMD, i, int'(cmd_mem[i])));
      exp_q.push_back(mk_ev(K_STS, 0, 'h20));
    end
    if (exp_code == 0 || exp_code >= 3)
      for (int i = 0; i < 6; i++) exp_q.push_back(mk_ev(K_RSP, i, int'(dev_mem[i])));
    if (exp_code == 0 || exp_code >= 4)
      for (int i = 6; i <= rsz - 2; i++) exp_q.push_back(mk_ev(K_RSP, i, int'(dev_mem[i])));
    if (exp_code == 0 || exp_code == 5)
      exp_q.push_back(mk_ev(K_RSP, rsz - 1, int'(dev_mem[rsz - 1])));
    if (exp_code == 0) exp_q.push_back(mk_ev(K_STS, 0, 'h40));
    cmd_len = LEN_W'(clen); max_rsp = LEN_W'(maxr); start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (clen >= 6) check(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    n = 0;
    while (!(done || err_stb) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(!(done && err_stb), "R12", "done and err together", int'(done & err_stb), 0);
    if (exp_code == 0) begin
      check(done == 1'b1, "R11", "done pulse", int'(done), 1);
      check(int'(rsp_len) == rsz, "R11", "rsp_len", int'(rsp_len), rsz);
      check(err_code == 3'd0, "R11", "err_code on success", int'(err_code), 0);
    end else begin
      check(err_stb == 1'b1, code_req(exp_code), "err strobe", int'(err_stb), 1);
      check(int'(err_code) == exp_code, code_req(exp_code), "err_code", int'(err_code), exp_code);
    end
    @(negedge clk);
    check(!busy && !done && !err_stb, "R12", "idle after strobe", int'({busy, done, err_stb}), 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, code_req(exp_code), "events left over", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset and right after it
    check(!busy && !done && !err_stb && !rsp_we, "R1", "status outputs in reset",
          int'({busy, done, err_stb, rsp_we}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!reg_req && !fifo_req, "R1", "port requests after reset", int'({reg_req, fifo_req}), 0);

    // R3 R4 R5 R7 R11: ordinary exchange, ready on the third poll
    run_xchg(10, 10, 12, 3, 0, 64, 0);
    check(polls == 3, "R5", "polls until ready", polls, 3);
    // R8 boundary: shortest legal response, no body bytes
    run_xchg(6, 6, 7, 1, 0, 64, 0);
    // R2: size field disagrees with the length
    run_xchg(10, 11, 12, 1, 0, 64, 1);
    check(sts_writes == 0, "R2", "status writes after size mismatch", sts_writes, 0);
    // R2: command shorter than a header
    run_xchg(4, 4, 12, 1, 0, 64, 1);
    // R6: device never ready
    run_xchg(8, 8, 12, 0, 0, 64, 2);
    check(polls == TIMEOUT_MS, "R6", "polls before timeout", polls, TIMEOUT_MS);
    // R8: response longer than allowed, then shorter than a header plus one
    run_xchg(8, 8, 40, 2, 0, 20, 3);
    run_xchg(8, 8, 6, 2, 0, 20, 3);
    // R8 boundary: response exactly at the limit
    run_xchg(8, 8, 20, 2, 0, 20, 0);
    // R9: data-available drops before the last byte
    run_xchg(8, 8, 12, 1, 1, 64, 4);
    // R10: data-available still set after the last byte
    run_xchg(8, 8, 12, 1, 2, 64, 5);
    check(sts_writes == 2, "R10", "no ready write after bad end status", sts_writes, 2);
    // R11: clean exchange after failures
    run_xchg(16, 16, 30, 5, 0, 64, 0);
    check(polls == 5, "R5", "polls until ready", polls, 5);

    $display("test done: total=%0d bad=%0d", tb_checks + mon_checks, tb_fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog run did not finish act=hung exp=done");
    $display("test done: total=%0d bad=%0d", tb_checks + mon_checks + 1, tb_fails + mon_fails + wd_fail);
    $finish;
  end
endmodule